// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the per-channel sequencing core of a direct memory access engine. A start strobe loads a source address, a destination address and a count of transfers. Each time the surrounding datapath reports that one transfer has finished, the block moves each address forward by the element width, if stepping is enabled for that side, and reduces the remaining count by one. When the count runs out, the block drops its busy flag and raises a completion pulse for one cycle.

One side, either source or destination, can be confined to a naturally aligned power-of-two ring. Only the low address bits then move, and the bits above the ring boundary keep the value they had at start. This suits circular buffers. Data words passing through the channel can also be byte-reversed according to the element width.

A settings register holds the channel controls. A one-cycle write strobe updates it, and it returns to defaults on reset. The block has no bus protocol, no arbitration between channels and no interrupt logic.

Top module: `dmag_channel`

## Requirements
- R1: After reset the block is idle: `busy`, `done_pulse` and `issue` are 0, both addresses read 0 and `remaining` is 0. The settings take their defaults: enabled, source stepping on, destination stepping off, width code 2 (32-bit), ring off and swap off.
- R2: A `start` pulse while enabled and idle loads both addresses and the count in the next cycle. `busy` rises only if the loaded count is non-zero.
- R3: The width code `set_size` uses 0 for 8 bits, 1 for 16 bits and 2 for 32 bits, and a stepping address advances by 1, 2 or 4 bytes to match. Code 3 steps like code 2.
- R4: Source and destination stepping are enabled separately. A side with stepping off keeps the same address for every transfer.
- R5: With `set_ring_bits` = n from 1 to 15, the ring side changes only its low n address bits, so it wraps inside an aligned 2^n-byte window and the bits above n hold their start value. With n = 0 there is no wrapping.
- R6: When `set_ring_wr` is 1 the ring applies to the destination address. When it is 0 the ring applies to the source address. The other side always steps without wrapping.
- R7: With `set_swap` on, width code 0 passes data unchanged, code 1 exchanges the two bytes in each 16-bit half, and code 2 reverses the four bytes of the word. With `set_swap` off, data passes unchanged.
- R8: The count is in transfers. Each `xfer_done` taken while busy lowers `remaining` by 1. When it reaches zero, `busy` falls and `done_pulse` is high for exactly that one cycle.
- R9: While disabled, `start` and `xfer_done` are ignored, the addresses and count hold, `busy` keeps its value and `issue` is 0.
- R10: A `start` arriving while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_wr | input | 1 | Write strobe for the settings register |
| set_en | input | 1 | Channel enable |
| set_rd_inc | input | 1 | Source address stepping |
| set_wr_inc | input | 1 | Destination address stepping |
| set_size | input | 2 | Element width code |
| set_ring_bits | input | 4 | Ring size exponent, 0 = off |
| set_ring_wr | input | 1 | Ring side: 1 destination, 0 source |
| set_swap | input | 1 | Byte reversal enable |
| start | input | 1 | Load addresses and count and begin |
| start_rd_addr | input | AW | Initial source address |
| start_wr_addr | input | AW | Initial destination address |
| start_count | input | CW | Number of transfers |
| xfer_done | input | 1 | One transfer has completed |
| data_in | input | DW | Data read from the source |
| data_out | output | DW | Data after optional byte reversal |
| rd_addr | output | AW | Current source address |
| wr_addr | output | AW | Current destination address |
| remaining | output | CW | Transfers still to do |
| busy | output | 1 | Sequence in progress |
| issue | output | 1 | Channel may issue transfers now |
| done_pulse | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The assertions assume that the settings register is not rewritten in the middle of a stepping transfer in a way that changes the ring window that transfer sees. They also assume that `xfer_done` only means something while the channel is busy. The directed stimulus writes the settings only between sequences, or to toggle the enable while a sequence is paused. It pulses `xfer_done` no more times than the count loaded. Each ring case starts from an address close to the window boundary, so a single step has to wrap.

// File: rtl/dmag_pkg.sv
// Package: shared settings type and reset defaults for the DMA channel sequencer.
// Assumes: width code 3 is never meant, and is treated as 32-bit.
package dmag_pkg;

    typedef struct packed {
        logic       en;
        logic       rd_inc;
        logic       wr_inc;
        logic [1:0] size;
        logic [3:0] ring_bits;
        logic       ring_wr;
        logic       swap;
    } dmag_cfg_t;

    localparam dmag_cfg_t CFG_RESET = '{
        en:        1'b1,
        rd_inc:    1'b1,
        wr_inc:    1'b0,
        size:      2'd2,
        ring_bits: 4'd0,
        ring_wr:   1'b0,
        swap:      1'b0
    };

    // Clamp the width code so that code 3 acts as 32-bit.
    function automatic logic [1:0] size_clamp(input logic [1:0] s);
        return (s == 2'd3) ? 2'd2 : s;
    endfunction

endpackage

// File: rtl/dmag_addr_gen.sv
// Module: one address register that steps by the element width, with an optional
// aligned power-of-two wrap that keeps the bits above the window fixed.
// Assumes: load and adv are never high together; wrap_bits is 0 when this side has no ring.
module dmag_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          adv,
    input  logic          inc_en,
    input  logic [1:0]    size,
    input  logic [3:0]    wrap_bits,
    output logic [AW-1:0] addr
);
    import dmag_pkg::*;

    logic [AW-1:0] step;
    logic [AW-1:0] stepped;
    logic [AW-1:0] win_mask;
    logic [AW-1:0] next_addr;

    // Work out the step, the window mask and the next address.
    always_comb begin
        step     = AW'(1) << size_clamp(size);
        stepped  = addr + step;
        win_mask = (AW'(1) << wrap_bits) - AW'(1);
        if (wrap_bits != 4'd0)
            next_addr = (addr & ~win_mask) | (stepped & win_mask);
        else
            next_addr = stepped;
    end

    // Address register: load on start, step on each completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_addr;
        else if (adv && inc_en)
            addr <= next_addr;
    end

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && inc_en && !load && wrap_bits != 4'd0) |=> (((addr ^ $past(addr)) & ~$past(win_mask)) == '0)); // R5
    AST_HOLD_NOINC: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !inc_en && !load) |=> $stable(addr)); // R4

endmodule

// File: rtl/dmag_counter.sv
// Module: remaining-transfer counter with busy flag and completion pulse.
// Assumes: load only arrives while idle and dec only while busy.
module dmag_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_count,
    input  logic          dec,
    output logic [CW-1:0] remaining,
    output logic          busy,
    output logic          done_pulse
);

    // Count, busy and the one-cycle pulse at the end of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining  <= '0;
            busy       <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (load) begin
                remaining <= load_count;
                busy      <= (load_count != '0);
            end else if (dec && busy) begin
                remaining <= remaining - CW'(1);
                if (remaining == CW'(1)) begin
                    busy       <= 1'b0;
                    done_pulse <= 1'b1;
                end
            end
        end
    end

    AST_BUSY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remaining != '0)); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !busy); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R8

endmodule

// File: rtl/dmag_swap.sv
// Module: byte-lane reversal that depends on the element width.
// Assumes: DW is a multiple of 32; code 3 acts as 32-bit.
module dmag_swap #(
    parameter int DW = 32
) (
    input  logic          swap_en,
    input  logic [1:0]    size,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    import dmag_pkg::*;

    localparam int LANES = DW / 8;

    logic [1:0] sz;
    assign sz = size_clamp(size);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SRC_H = i ^ 1;
        localparam int SRC_W = (i & ~3) | (3 - (i & 3));
        // Pick the source byte for this lane.
        always_comb begin
            if (!swap_en || sz == 2'd0)
                dout[i*8 +: 8] = din[i*8 +: 8];
            else if (sz == 2'd1)
                dout[i*8 +: 8] = din[SRC_H*8 +: 8];
            else
                dout[i*8 +: 8] = din[SRC_W*8 +: 8];
        end
    end

endmodule

// File: rtl/dmag_channel.sv
// Module: top of the DMA channel sequencer. Holds the settings register, routes the
// ring to one side, and connects two address generators, the counter and the byte swap.
// Assumes: xfer_done is pulsed by the datapath only for transfers this channel issued.
module dmag_channel #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_wr,
    input  logic          set_en,
    input  logic          set_rd_inc,
    input  logic          set_wr_inc,
    input  logic [1:0]    set_size,
    input  logic [3:0]    set_ring_bits,
    input  logic          set_ring_wr,
    input  logic          set_swap,
    input  logic          start,
    input  logic [AW-1:0] start_rd_addr,
    input  logic [AW-1:0] start_wr_addr,
    input  logic [CW-1:0] start_count,
    input  logic          xfer_done,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic [CW-1:0] remaining,
    output logic          busy,
    output logic          issue,
    output logic          done_pulse
);
    import dmag_pkg::*;

    localparam int SIDES = 2;   // 0 = source, 1 = destination

    dmag_cfg_t cfg_q;
    logic      take_start;
    logic      take_done;

    logic [AW-1:0] side_load [SIDES];
    logic          side_inc  [SIDES];
    logic [3:0]    side_wrap [SIDES];
    logic [AW-1:0] side_addr [SIDES];

    // Settings register: written by strobe, defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (set_wr)
            cfg_q <= '{en: set_en, rd_inc: set_rd_inc, wr_inc: set_wr_inc, size: set_size,
                       ring_bits: set_ring_bits, ring_wr: set_ring_wr, swap: set_swap};
    end

    // Accept events only when enabled; a start is also refused while busy.
    always_comb begin
        take_start = start && cfg_q.en && !busy;
        take_done  = xfer_done && cfg_q.en && busy;
        issue      = busy && cfg_q.en;
    end

    // Per-side inputs: start address, stepping enable and ring window.
    always_comb begin
        side_load[0] = start_rd_addr;
        side_load[1] = start_wr_addr;
        side_inc[0]  = cfg_q.rd_inc;
        side_inc[1]  = cfg_q.wr_inc;
        side_wrap[0] = cfg_q.ring_wr ? 4'd0 : cfg_q.ring_bits;
        side_wrap[1] = cfg_q.ring_wr ? cfg_q.ring_bits : 4'd0;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dmag_addr_gen #(.AW(AW)) u_addr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (take_start),
            .load_addr (side_load[s]),
            .adv       (take_done),
            .inc_en    (side_inc[s]),
            .size      (cfg_q.size),
            .wrap_bits (side_wrap[s]),
            .addr      (side_addr[s])
        );
    end

    assign rd_addr = side_addr[0];
    assign wr_addr = side_addr[1];

    dmag_counter #(.CW(CW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take_start),
        .load_count (start_count),
        .dec        (take_done),
        .remaining  (remaining),
        .busy       (busy),
        .done_pulse (done_pulse)
    );

    dmag_swap #(.DW(DW)) u_swap (
        .swap_en (cfg_q.swap),
        .size    (cfg_q.size),
        .din     (data_in),
        .dout    (data_out)
    );

    AST_PAUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_q.en) |=> busy); // R9
    AST_PAUSE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en && !set_wr && $past(!cfg_q.en)) |=> $stable(rd_addr) && $stable(remaining)); // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(remaining) || $past(xfer_done)); // R10

endmodule

// File: tb/sim_dmag_channel.sv
`timescale 1ns/1ps
module sim_dmag_channel;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          set_wr = 1'b0;
    logic          set_en = 1'b1;
    logic          set_rd_inc = 1'b1;
    logic          set_wr_inc = 1'b0;
    logic [1:0]    set_size = 2'd2;
    logic [3:0]    set_ring_bits = 4'd0;
    logic          set_ring_wr = 1'b0;
    logic          set_swap = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_rd_addr = '0;
    logic [AW-1:0] start_wr_addr = '0;
    logic [CW-1:0] start_count = '0;
    logic          xfer_done = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;
    logic [CW-1:0] remaining;
    logic          busy;
    logic          issue;
    logic          done_pulse;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    dmag_channel #(.AW(AW), .CW(CW), .DW(DW)) u0 (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic ri, input logic wi, input logic [1:0] sz,
                             input logic [3:0] rb, input logic rw, input logic sw);
        @(negedge clk);
        set_wr = 1'b1; set_en = en; set_rd_inc = ri; set_wr_inc = wi; set_size = sz;
        set_ring_bits = rb; set_ring_wr = rw; set_swap = sw;
        @(negedge clk);
        set_wr = 1'b0;
    endtask

    task automatic do_start(input logic [31:0] ra, input logic [31:0] wa, input logic [CW-1:0] cnt);
        @(negedge clk);
        start = 1'b1; start_rd_addr = ra; start_wr_addr = wa; start_count = cnt;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic one_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done_pulse", 32'(done_pulse), 0);
        chk("R1", "issue", 32'(issue), 0);
        chk("R1", "rd_addr", rd_addr, 0);
        chk("R1", "wr_addr", wr_addr, 0);
        chk("R1", "remaining", 32'(remaining), 0);
    endtask

    // Default settings: source steps by 4, destination fixed, no swap.
    task automatic t_defaults_and_count();
        do_start(32'h1000, 32'h2000, 16'd3);
        chk("R2", "busy after start", 32'(busy), 1);
        chk("R2", "rd load", rd_addr, 32'h1000);
        chk("R2", "wr load", wr_addr, 32'h2000);
        chk("R1", "issue default enabled", 32'(issue), 1);
        data_in = 32'h11223344;
        #0.1;
        chk("R1", "swap off by default", data_out, 32'h11223344);
        one_done();
        chk("R1", "rd step default 4", rd_addr, 32'h1004);
        chk("R1", "wr fixed default", wr_addr, 32'h2000);
        chk("R8", "remaining", 32'(remaining), 2);
        one_done();
        chk("R8", "busy mid", 32'(busy), 1);
        one_done();
        chk("R8", "busy falls", 32'(busy), 0);
        chk("R8", "done pulse", 32'(done_pulse), 1);
        chk("R8", "rd final", rd_addr, 32'h100C);
        @(negedge clk);
        chk("R8", "done pulse single", 32'(done_pulse), 0);
    endtask

    task automatic t_sizes();
        write_cfg(1, 1, 1, 2'd1, 0, 0, 0);
        do_start(32'h10, 32'h20, 16'd2);
        one_done();
        chk("R3", "rd step 2", rd_addr, 32'h12);
        chk("R3", "wr step 2", wr_addr, 32'h22);
        one_done();
        write_cfg(1, 1, 0, 2'd0, 0, 0, 0);
        do_start(32'h10, 32'h20, 16'd2);
        one_done();
        chk("R3", "rd step 1", rd_addr, 32'h11);
        chk("R4", "wr held with inc off", wr_addr, 32'h20);
        one_done();
        write_cfg(1, 0, 1, 2'd3, 0, 0, 0);
        do_start(32'h10, 32'h20, 16'd1);
        one_done();
        chk("R4", "rd held with inc off", rd_addr, 32'h10);
        chk("R3", "code 3 steps 4", wr_addr, 32'h24);
    endtask

    task automatic t_ring();
        write_cfg(1, 1, 1, 2'd2, 4'd4, 0, 0);
        do_start(32'h0000AB0C, 32'h00005FFC, 16'd2);
        one_done();
        chk("R5", "rd wraps in 16B window", rd_addr, 32'h0000AB00);
        chk("R6", "wr not wrapped when ring on read", wr_addr, 32'h00006000);
        one_done();
        chk("R5", "rd steps inside window", rd_addr, 32'h0000AB04);
        write_cfg(1, 1, 1, 2'd2, 4'd4, 1, 0);
        do_start(32'h0000AB0C, 32'h00005FFC, 16'd1);
        one_done();
        chk("R6", "wr wraps when ring on write", wr_addr, 32'h00005FF0);
        chk("R6", "rd not wrapped", rd_addr, 32'h0000AB10);
        write_cfg(1, 1, 0, 2'd2, 4'd15, 0, 0);
        do_start(32'h00017FFC, 32'h0, 16'd1);
        one_done();
        chk("R5", "n=15 wrap keeps upper bits", rd_addr, 32'h00010000);
        write_cfg(1, 1, 0, 2'd0, 4'd1, 0, 0);
        do_start(32'hF0000001, 32'h0, 16'd1);
        one_done();
        chk("R5", "n=1 two-byte ring", rd_addr, 32'hF0000000);
    endtask

    task automatic t_swap();
        data_in = 32'h11223344;
        write_cfg(1, 1, 0, 2'd0, 0, 0, 1);
        chk("R7", "byte unchanged", data_out, 32'h11223344);
        write_cfg(1, 1, 0, 2'd1, 0, 0, 1);
        chk("R7", "halfword swap", data_out, 32'h22114433);
        write_cfg(1, 1, 0, 2'd2, 0, 0, 1);
        chk("R7", "word reverse", data_out, 32'h44332211);
        write_cfg(1, 1, 0, 2'd2, 0, 0, 0);
        chk("R7", "swap off word", data_out, 32'h11223344);
    endtask

    task automatic t_disable();
        write_cfg(1, 1, 1, 2'd2, 0, 0, 0);
        do_start(32'h300, 32'h400, 16'd2);
        write_cfg(0, 1, 1, 2'd2, 0, 0, 0);
        chk("R9", "issue low when disabled", 32'(issue), 0);
        one_done();
        chk("R9", "busy held", 32'(busy), 1);
        chk("R9", "rd held", rd_addr, 32'h300);
        chk("R9", "count held", 32'(remaining), 2);
        write_cfg(1, 1, 1, 2'd2, 0, 0, 0);
        one_done();
        one_done();
        chk("R8", "finished after resume", 32'(busy), 0);
        write_cfg(0, 1, 1, 2'd2, 0, 0, 0);
        do_start(32'h500, 32'h600, 16'd4);
        chk("R9", "start ignored when disabled", 32'(busy), 0);
        chk("R9", "rd not loaded when disabled", rd_addr, 32'h308);
        write_cfg(1, 1, 1, 2'd2, 0, 0, 0);
    endtask

    task automatic t_restart_and_zero();
        do_start(32'h700, 32'h800, 16'd2);
        do_start(32'h900, 32'hA00, 16'd9);
        chk("R10", "rd unchanged by start while busy", rd_addr, 32'h700);
        chk("R10", "count unchanged", 32'(remaining), 2);
        one_done();
        one_done();
        do_start(32'hB00, 32'hC00, 16'd0);
        chk("R2", "zero count no busy", 32'(busy), 0);
        chk("R2", "zero count loads rd", rd_addr, 32'hB00);
        @(negedge clk);
        chk("R2", "zero count no done", 32'(done_pulse), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_defaults_and_count();
        t_sizes();
        t_ring();
        t_swap();
        t_disable();
        t_restart_and_zero();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule